// File: doc/BRIEF.md
# Subroutine Call Program Counter Unit

This block owns the program counter of a small processor with an 11-bit instruction address space. Each cycle it either advances the counter by one or, when the decoder raises a call or return strobe, redirects it. A call target is formed from an 8-bit immediate in the low byte, a forced-zero bit 8, and two page-select bits supplied by the status register in bits 10:9. Because bit 8 is forced to zero, a call can only enter the lower half of a 512-word page.

A call saves the address after the calling instruction on a two-entry hardware return stack, and a return reloads the whole 11-bit counter from the top of that stack. Both take two cycles. In the cycle after the redirect, the word already fetched from the old path is turned into a no-operation by a fetch-invalidate output, and strobes are not accepted. The stack never flags an error. A push onto a full stack drops the oldest entry, and a pop leaves the bottom entry in place.

Top module: `pcu_call_unit`

## Requirements
- R1: Synchronous active-low reset clears the counter to 0x000, clears the fetch-invalidate output and clears both stack entries to 0x000. A return issued straight after reset therefore loads 0x000.
- R2: With no accepted strobe, the counter rises by one each cycle and wraps from 0x7FF to 0x000.
- R3: An accepted call loads the counter on the next edge. Bits 7:0 come from the immediate, bit 8 is 0, and bits 10:9 come from page bits [1:0].
- R4: An accepted call pushes the counter value plus one (mod 2^11) onto the stack, so a call issued at 0x7FF later returns to 0x000.
- R5: The fetch-invalidate output is high for exactly the one cycle that follows an accepted call or return, and low at all other times.
- R6: While the fetch-invalidate output is high, call and return strobes are ignored and the counter advances by one.
- R7: An accepted return loads the whole counter from the top stack entry, and nested calls return in last-in, first-out order.
- R8: A third push without an intervening pop overwrites the oldest entry. A pop copies the bottom entry upward and keeps it, so repeated returns keep yielding the bottom value.
- R9: If call and return are strobed in the same cycle, the call is taken and nothing is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_req | input | 1 | Call strobe from the decoder |
| ret_req | input | 1 | Return strobe from the decoder |
| call_imm | input | 8 | Immediate call target, low byte of the new address |
| page_sel | input | 2 | Page-select bits taken from the status register |
| pc | output | 11 | Current program counter |
| fetch_kill | output | 1 | Replace the fetched word with a no-operation |

## Verification
The bench goes after overflow of the two-entry stack. A design that refused the third push, or cleared the bottom entry on a pop, would return to the wrong address once the stack was exhausted. It checks that bit 8 is zero and the page bits land in 10:9; a design that shifted them, or kept the old bit 8, would enter the wrong half page. It drives strobes during the invalidate cycle and a simultaneous call and return. A design that accepted the first would jump twice in a row, and one that honoured both would lose a stack entry. Finally it walks the counter across 0x7FF, both on plain increment and as the pushed return address of a call, where a width error shows up as a return to 0x800 or to an unchanged address.

// File: rtl/pcu_pkg.sv
// Package: shared types and helpers for the call program counter unit.
// Assumes: address widths are small enough that plain modular addition fits.
package pcu_pkg;

    // Sequencer phase: ready for a new instruction, or discarding one fetch
    typedef enum logic [0:0] {
        PH_RUN   = 1'b0,
        PH_FLUSH = 1'b1
    } pcu_phase_t;

    // Stack operation issued by the sequencer for this cycle
    typedef enum logic [1:0] {
        STK_HOLD = 2'b00,
        STK_PUSH = 2'b01,
        STK_POP  = 2'b10
    } pcu_stk_op_t;

endpackage

// File: rtl/pcu_target_gen.sv
// Module: builds the call destination from the immediate and page bits.
// Layout of the result, high to low: page bits, forced-zero gap, immediate.
// Assumes: ADDR_W >= PAGE_W + IMM_W.
module pcu_target_gen #(
    parameter int ADDR_W = 11,
    parameter int IMM_W  = 8,
    parameter int PAGE_W = 2
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [PAGE_W-1:0] page,
    output logic [ADDR_W-1:0] target
);
    localparam int GAP_W = ADDR_W - PAGE_W - IMM_W;

    generate
        if (GAP_W > 0) begin : g_gap
            // Concatenate page, zero gap and immediate
            always_comb begin
                target = {page, {GAP_W{1'b0}}, imm};
            end
        end else begin : g_nogap
            // No gap: page sits directly above the immediate
            always_comb begin
                target = {page, imm};
            end
        end
    endgenerate

    // R3: the gap bits of a built target are always zero
    always_comb begin
        if (GAP_W > 0) begin
            a_r3_gap_zero: assert (target[ADDR_W-PAGE_W-1 -: ((GAP_W > 0) ? GAP_W : 1)] == '0);
        end
    end
endmodule

// File: rtl/pcu_ret_stack.sv
// Module: fixed-depth return-address stack built as a shift register.
// A push shifts every entry down one slot and loses the deepest entry.
// A pop shifts entries up and leaves the deepest entry unchanged.
// No empty or full detection. Assumes: DEPTH >= 2.
module pcu_ret_stack
    import pcu_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pcu_stk_op_t       op,
    input  logic [ADDR_W-1:0] push_data,
    output logic [ADDR_W-1:0] top
);
    localparam int LAST = DEPTH - 1;

    logic [ADDR_W-1:0] ent [DEPTH];

    // Slot 0 is the top of stack
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent[0] <= '0;
        end else if (op == STK_PUSH) begin
            ent[0] <= push_data;
        end else if (op == STK_POP) begin
            ent[0] <= ent[1];
        end
    end

    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_slot
            if (i < LAST) begin : g_mid
                // Middle slots shift on push and on pop
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        ent[i] <= '0;
                    end else if (op == STK_PUSH) begin
                        ent[i] <= ent[i-1];
                    end else if (op == STK_POP) begin
                        ent[i] <= ent[i+1];
                    end
                end
            end else begin : g_last
                // Deepest slot takes the entry above it on push and holds on pop
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        ent[i] <= '0;
                    end else if (op == STK_PUSH) begin
                        ent[i] <= ent[i-1];
                    end
                end
            end
        end
    endgenerate

    assign top = ent[0];

    // R4: a pushed value becomes the top entry
    a_r4_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_PUSH) |=> (top == $past(push_data)));

    // R8: the deepest entry survives a pop
    a_r8_pop_keeps_last: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_POP) |=> (ent[LAST] == $past(ent[LAST])));

    // R8: a pop exposes the old second entry
    a_r8_pop_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (op == STK_POP) |=> (top == $past(ent[1])));
endmodule

// File: rtl/pcu_sequencer.sv
// Module: holds the program counter and the two-cycle redirect phase.
// Accepts a call or return only in the run phase. A call wins over a return.
// Each redirect is followed by one flush cycle that raises fetch_kill.
// Assumes: target and stack top are valid in the cycle the strobe is high.
module pcu_sequencer
    import pcu_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic [ADDR_W-1:0] call_target,
    input  logic [ADDR_W-1:0] stack_top,
    output logic [ADDR_W-1:0] pc,
    output logic              fetch_kill,
    output pcu_stk_op_t       stk_op,
    output logic [ADDR_W-1:0] ret_addr
);
    pcu_phase_t        phase;
    logic              call_go;
    logic              ret_go;
    logic [ADDR_W-1:0] pc_inc;

    // Decide which strobe, if any, is accepted this cycle
    always_comb begin
        call_go = call_req && (phase == PH_RUN);
        ret_go  = ret_req && !call_req && (phase == PH_RUN);
        pc_inc  = pc + ADDR_W'(1);
    end

    // Issue the stack operation and the return address to save
    always_comb begin
        ret_addr = pc_inc;
        if (call_go) begin
            stk_op = STK_PUSH;
        end else if (ret_go) begin
            stk_op = STK_POP;
        end else begin
            stk_op = STK_HOLD;
        end
    end

    // Program counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (call_go) begin
            pc <= call_target;
        end else if (ret_go) begin
            pc <= stack_top;
        end else begin
            pc <= pc_inc;
        end
    end

    // Phase register: one flush cycle after each redirect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_RUN;
        end else if (call_go || ret_go) begin
            phase <= PH_FLUSH;
        end else begin
            phase <= PH_RUN;
        end
    end

    assign fetch_kill = (phase == PH_FLUSH);

    // R5: the invalidate pulse lasts a single cycle
    a_r5_kill_single: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_kill |=> !fetch_kill);

    // R5: a redirect is always followed by the invalidate pulse
    a_r5_kill_after_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (call_go || ret_go) |=> fetch_kill);

    // R6: during the flush cycle the counter only advances
    a_r6_flush_advances: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_kill |=> (pc == $past(pc) + ADDR_W'(1)));

    // R2: with no strobe the counter advances by one
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_req && !ret_req) |=> (pc == $past(pc) + ADDR_W'(1)));

    // R9: a simultaneous call and return never pops
    a_r9_call_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && ret_req) |-> (stk_op != STK_POP));
endmodule

// File: rtl/pcu_call_unit.sv
// Module: top of the call program counter unit.
// Joins target formation, the return stack and the counter sequencer.
// Assumes: page_sel is the status register's page field, stable when call_req is high.
module pcu_call_unit
    import pcu_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int IMM_W       = 8,
    parameter int PAGE_W      = 2,
    parameter int STACK_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic [IMM_W-1:0]  call_imm,
    input  logic [PAGE_W-1:0] page_sel,
    output logic [ADDR_W-1:0] pc,
    output logic              fetch_kill
);
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] stack_top;
    logic [ADDR_W-1:0] ret_addr;
    pcu_stk_op_t       stk_op;

    pcu_target_gen #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W),
        .PAGE_W (PAGE_W)
    ) u_target (
        .imm    (call_imm),
        .page   (page_sel),
        .target (target)
    );

    pcu_ret_stack #(
        .ADDR_W (ADDR_W),
        .DEPTH  (STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (stk_op),
        .push_data (ret_addr),
        .top       (stack_top)
    );

    pcu_sequencer #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .call_req    (call_req),
        .ret_req     (ret_req),
        .call_target (target),
        .stack_top   (stack_top),
        .pc          (pc),
        .fetch_kill  (fetch_kill),
        .stk_op      (stk_op),
        .ret_addr    (ret_addr)
    );

    // R3: an accepted call lands on the immediate within the selected page
    a_r3_call_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !fetch_kill) |=>
            (pc[IMM_W-1:0] == $past(call_imm)) &&
            (pc[ADDR_W-1 -: PAGE_W] == $past(page_sel)));
endmodule

// File: tb/tb_pcu_call_unit.sv
// Testbench: vector table walked by one loop, then directed reset and wrap tests.
module tb_pcu_call_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0;
    logic        ret_req = 1'b0;
    logic [7:0]  call_imm = '0;
    logic [1:0]  page_sel = '0;
    logic [10:0] pc;
    logic        fetch_kill;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcu_call_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .call_req   (call_req),
        .ret_req    (ret_req),
        .call_imm   (call_imm),
        .page_sel   (page_sel),
        .pc         (pc),
        .fetch_kill (fetch_kill)
    );

    // Fields: call, ret, imm[7:0], page[1:0], expected pc[10:0], expected kill
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'h00, 2'b00, 11'h001, 1'b0}, // R2 step
        {1'b1, 1'b0, 8'h34, 2'b11, 11'h634, 1'b1}, // R3 call, pushes 0x002
        {1'b1, 1'b0, 8'hFF, 2'b00, 11'h635, 1'b0}, // R6 call ignored in flush
        {1'b0, 1'b0, 8'h00, 2'b00, 11'h636, 1'b0}, // R2 step
        {1'b1, 1'b0, 8'h80, 2'b01, 11'h280, 1'b1}, // R3 bit 8 zero, pushes 0x637
        {1'b0, 1'b0, 8'h00, 2'b00, 11'h281, 1'b0}, // R5 pulse ends
        {1'b1, 1'b0, 8'h05, 2'b00, 11'h005, 1'b1}, // R8 third push, pushes 0x282
        {1'b0, 1'b0, 8'h00, 2'b00, 11'h006, 1'b0}, // R2 step
        {1'b0, 1'b1, 8'h00, 2'b00, 11'h282, 1'b1}, // R7 return to newest
        {1'b0, 1'b1, 8'h00, 2'b00, 11'h283, 1'b0}, // R6 return ignored in flush
        {1'b0, 1'b1, 8'h00, 2'b00, 11'h637, 1'b1}, // R7 LIFO second return
        {1'b0, 1'b0, 8'h00, 2'b00, 11'h638, 1'b0}, // R2 step
        {1'b0, 1'b1, 8'h00, 2'b00, 11'h637, 1'b1}, // R8 bottom entry kept
        {1'b0, 1'b0, 8'h00, 2'b00, 11'h638, 1'b0}, // R2 step
        {1'b1, 1'b1, 8'h11, 2'b10, 11'h411, 1'b1}, // R9 call wins, pushes 0x639
        {1'b0, 1'b0, 8'h00, 2'b00, 11'h412, 1'b0}, // R2 step
        {1'b0, 1'b1, 8'h00, 2'b00, 11'h639, 1'b1}  // R9 nothing was popped
    };

    task automatic check(input string req, input logic [10:0] exp_pc, input logic exp_kill);
        checks++;
        if (pc !== exp_pc || fetch_kill !== exp_kill) begin
            failures++;
            $display("FAIL %s: pc=%h kill=%b expected pc=%h kill=%b",
                     req, pc, fetch_kill, exp_pc, exp_kill);
        end
    endtask

    // Drive inputs just after a falling edge; return after the next falling edge
    task automatic cyc(input logic c, input logic r, input logic [7:0] imm, input logic [1:0] pg);
        call_req = c;
        ret_req  = r;
        call_imm = imm;
        page_sel = pg;
        @(negedge clk);
        call_req = 1'b0;
        ret_req  = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        call_req = 1'b0;
        ret_req = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset", 11'h000, 1'b0);
        rst_n = 1'b1;
    endtask

    // Move to 0x7FF: call to 0x6FF, then 256 plain steps
    task automatic go_top();
        cyc(1'b1, 1'b0, 8'hFF, 2'b11);
        check("R3 call to 0x6FF", 11'h6FF, 1'b1);
        for (int i = 0; i < 256; i++) cyc(1'b0, 1'b0, 8'h00, 2'b00);
        check("R2 reach top", 11'h7FF, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        for (int i = 0; i < NVEC; i++) begin
            cyc(VEC[i][23], VEC[i][22], VEC[i][21:14], VEC[i][13:12]);
            check($sformatf("vector %0d", i), VEC[i][11:1], VEC[i][0]);
        end

        // R1: reset mid-run clears the stack; a return then loads 0x000
        do_reset();
        cyc(1'b0, 1'b1, 8'h00, 2'b00);
        check("R1 stack cleared", 11'h000, 1'b1);
        cyc(1'b0, 1'b0, 8'h00, 2'b00);
        check("R1 step after return", 11'h001, 1'b0);

        // R2: wrap from 0x7FF to 0x000
        go_top();
        cyc(1'b0, 1'b0, 8'h00, 2'b00);
        check("R2 wrap", 11'h000, 1'b0);

        // R4: call issued at 0x7FF saves 0x000
        go_top();
        cyc(1'b1, 1'b0, 8'h10, 2'b00);
        check("R4 call at top", 11'h010, 1'b1);
        cyc(1'b0, 1'b0, 8'h00, 2'b00);
        check("R5 pulse ends", 11'h011, 1'b0);
        cyc(1'b0, 1'b1, 8'h00, 2'b00);
        check("R4 return wraps", 11'h000, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule